// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that completes one instruction per clock. The subset it runs is small: five register-to-register operations (add, subtract, bitwise and, bitwise or, signed set-less-than), a word load and a word store, a branch on equality and an unconditional jump. Every instruction is finished within a single cycle. The core fetches the word at the program counter, decodes it, reads its two source registers, runs the ALU, optionally touches data memory, writes the result back and moves the program counter.

Instructions and data sit in two separate word-organised memories inside the core. A preload port fills either memory, and it is normally used while reset is held. The core exposes the current program counter and instruction. It also exposes the register write-back and the data-memory store of the instruction now executing, so that a caller can follow execution at the ports. Both memories index by byte address with the two low bits dropped, and they wrap modulo their depth.

There is no multi-cycle control: the only sequential state is the program counter, the 32-entry register file and the two memories. The state register is the PC, and its only transitions are the three next-PC choices: step, branch-taken and jump.

Top module: `mlite_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the PC to 0 and clears all 32 registers. Data memory is not cleared.
- R2: With opcode bits [31:26] = 000000, function bits [5:0] select add 100000, sub 100010, and 100100 and or 100101. The operands are registers rs [25:21] and rt [20:16], the result goes to register rd [15:11], and arithmetic wraps modulo 2^32.
- R3: Function 101010 (slt) writes 1 to rd when rs is less than rt as signed 32-bit values, and writes 0 otherwise.
- R4: Register 0 reads as zero at all times. A write-back addressed to it is still reported on the trace ports but leaves it unchanged.
- R5: Opcode 100011 (load) reads the data word at byte address rs + sign-extended bits [15:0] and writes it to register rt.
- R6: Opcode 101011 (store) writes rt to the data word at byte address rs + sign-extended bits [15:0] and writes no register.
- R7: Opcode 000100 (beq) sets the next PC to PC + 4 + (sign-extended bits [15:0] shifted left by 2) when rs equals rt, and to PC + 4 otherwise.
- R8: Opcode 000010 (jump) sets the next PC to {bits [31:28] of PC + 4, bits [25:0], 2'b00}.
- R9: Every instruction other than a taken branch or a jump advances the PC by 4.
- R10: Any other opcode, or opcode 000000 with any other function code, writes neither a register nor data memory, and advances the PC by 4.
- R11: With `prog_we` high at a rising edge, `prog_wdata` is written to word `prog_addr` of instruction memory when `prog_sel` = 0, or of data memory when `prog_sel` = 1. A preload write takes priority over a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Preload write strobe |
| prog_sel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| prog_addr | input | MEM_AW | Preload word index |
| prog_wdata | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction fetched at the PC |
| rf_we_o | output | 1 | Current instruction writes a register |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value written |
| dm_we_o | output | 1 | Current instruction stores to data memory |
| dm_addr_o | output | 32 | Byte address of the load or store |
| dm_wdata_o | output | 32 | Value stored |

## Verification
Two things fall on the same clock edge: the write-back of one instruction and the PC redirect that picks the next one. A load's memory read also feeds the write-back in the same cycle. The stimulus provokes these overlaps with back-to-back dependent instructions. It also uses a store followed by a load of the same word reached through a negative offset, branches whose outcome depends on a value written the cycle before, and writes aimed at register 0. Each cycle, an instruction-level reference model in the bench judges the PC, the register write-back and the store against its own state. The model is driven with directed programs and with seeded random programs.

// File: rtl/mlite_pkg.sv
package mlite_pkg;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_LOAD  = 6'b100011;
    localparam logic [5:0] OP_STORE = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_JUMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_is_rd;
        logic    use_imm;
        logic    load_to_reg;
        logic    mem_write;
        logic    branch;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/mlite_ctrl.sv
module mlite_ctrl
    import mlite_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl
);

    always_comb begin
        ctl        = '0;
        ctl.alu_op = ALU_ADD;
        unique case (opcode)
            OP_RTYPE: begin
                ctl.reg_write = 1'b1;
                ctl.dst_is_rd = 1'b1;
                unique case (funct)
                    FN_ADD:  ctl.alu_op = ALU_ADD;
                    FN_SUB:  ctl.alu_op = ALU_SUB;
                    FN_AND:  ctl.alu_op = ALU_AND;
                    FN_OR:   ctl.alu_op = ALU_OR;
                    FN_SLT:  ctl.alu_op = ALU_SLT;
                    default: ctl.reg_write = 1'b0;
                endcase
            end
            OP_LOAD: begin
                ctl.reg_write   = 1'b1;
                ctl.use_imm     = 1'b1;
                ctl.load_to_reg = 1'b1;
            end
            OP_STORE: begin
                ctl.mem_write = 1'b1;
                ctl.use_imm   = 1'b1;
            end
            OP_BEQ: begin
                ctl.branch = 1'b1;
                ctl.alu_op = ALU_SUB;
            end
            OP_JUMP:  ctl.jump = 1'b1;
            default:  ctl.reg_write = 1'b0;
        endcase
    end

endmodule

// File: rtl/mlite_alu.sv
module mlite_alu
    import mlite_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/mlite_regfile.sv
module mlite_regfile #(
    parameter int RAW = 5,
    parameter int W   = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [RAW-1:0] raddr_a,
    input  logic [RAW-1:0] raddr_b,
    output logic [W-1:0]   rdata_a,
    output logic [W-1:0]   rdata_b,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [W-1:0]   wdata
);

    localparam int NREG = 1 << RAW;

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

    // R4: the zero register never returns anything but zero
    a_r4_zero_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (raddr_a == '0) |-> (rdata_a == '0));

    // R2: a write to a nonzero register is visible on the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/mlite_wmem.sv
module mlite_wmem #(
    parameter int AW = 6,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [W-1:0]  core_wdata,
    input  logic          prog_we,
    input  logic [AW-1:0] prog_addr,
    input  logic [W-1:0]  prog_wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (prog_we)      cells[prog_addr] <= prog_wdata;
        else if (core_we) cells[core_addr] <= core_wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/mlite_core.sv
module mlite_core
    import mlite_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic              prog_sel,
    input  logic [MEM_AW-1:0] prog_addr,
    input  logic [31:0]       prog_wdata,
    output logic [31:0]       pc_o,
    output logic [31:0]       instr_o,
    output logic              rf_we_o,
    output logic [4:0]        rf_waddr_o,
    output logic [31:0]       rf_wdata_o,
    output logic              dm_we_o,
    output logic [31:0]       dm_addr_o,
    output logic [31:0]       dm_wdata_o
);

    localparam int XW  = 32;
    localparam int RAW = 5;

    logic [XW-1:0]  pc_q, pc_next, pc_plus4, br_target, j_target;
    logic [XW-1:0]  instr, rs_val, rt_val, imm_ext, alu_b, alu_y, dm_rdata, wb_data;
    logic [RAW-1:0] rs_idx, rt_idx, rd_idx, dst_idx;
    logic           br_taken, store_en;
    ctrl_t          ctl;

    // program counter: the only sequential control state
    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    mlite_wmem #(.AW(MEM_AW), .W(XW)) u_imem (
        .clk        (clk),
        .core_we    (1'b0),
        .core_addr  ('0),
        .core_wdata ('0),
        .prog_we    (prog_we && !prog_sel),
        .prog_addr  (prog_addr),
        .prog_wdata (prog_wdata),
        .raddr      (pc_q[MEM_AW+1:2]),
        .rdata      (instr)
    );

    assign rs_idx  = instr[25:21];
    assign rt_idx  = instr[20:16];
    assign rd_idx  = instr[15:11];
    assign imm_ext = {{16{instr[15]}}, instr[15:0]};

    mlite_ctrl u_ctrl (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl)
    );

    assign dst_idx = ctl.dst_is_rd ? rd_idx : rt_idx;

    mlite_regfile #(.RAW(RAW), .W(XW)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .raddr_a (rs_idx),
        .raddr_b (rt_idx),
        .rdata_a (rs_val),
        .rdata_b (rt_val),
        .we      (ctl.reg_write),
        .waddr   (dst_idx),
        .wdata   (wb_data)
    );

    assign alu_b = ctl.use_imm ? imm_ext : rt_val;

    mlite_alu #(.W(XW)) u_alu (
        .a  (rs_val),
        .b  (alu_b),
        .op (ctl.alu_op),
        .y  (alu_y)
    );

    assign store_en = ctl.mem_write && !rst;

    mlite_wmem #(.AW(MEM_AW), .W(XW)) u_dmem (
        .clk        (clk),
        .core_we    (store_en),
        .core_addr  (alu_y[MEM_AW+1:2]),
        .core_wdata (rt_val),
        .prog_we    (prog_we && prog_sel),
        .prog_addr  (prog_addr),
        .prog_wdata (prog_wdata),
        .raddr      (alu_y[MEM_AW+1:2]),
        .rdata      (dm_rdata)
    );

    assign wb_data = ctl.load_to_reg ? dm_rdata : alu_y;

    // next-PC selection: step, branch-taken or jump
    assign pc_plus4  = pc_q + 32'd4;
    assign br_target = pc_plus4 + {imm_ext[29:0], 2'b00};
    assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign br_taken  = ctl.branch && (alu_y == '0);

    always_comb begin
        if (ctl.jump)      pc_next = j_target;
        else if (br_taken) pc_next = br_target;
        else               pc_next = pc_plus4;
    end

    assign pc_o       = pc_q;
    assign instr_o    = instr;
    assign rf_we_o    = ctl.reg_write;
    assign rf_waddr_o = dst_idx;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = store_en;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;

    // R9: without a redirect the PC steps by one word
    a_r9_pc_step: assert property (@(posedge clk) disable iff (rst)
        (!ctl.branch && !ctl.jump) |=> (pc_q == $past(pc_q) + 32'd4));

    // R7: an untaken branch falls through
    a_r7_beq_fallthrough: assert property (@(posedge clk) disable iff (rst)
        (ctl.branch && rs_val != rt_val) |=> (pc_q == $past(pc_q) + 32'd4));

    // R8: a jump keeps the region bits of PC + 4 and stays word aligned
    a_r8_jump_region: assert property (@(posedge clk) disable iff (rst)
        ctl.jump |=> (pc_q[31:28] == $past(pc_q[31:28] + {3'b000, &pc_q[27:2]})
                      && pc_q[1:0] == 2'b00));

    // R6: a store never also writes a register
    a_r6_store_no_wb: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> !rf_we_o);

    // R10: an unknown opcode has no side effect
    a_r10_unknown_inert: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] != OP_RTYPE && instr[31:26] != OP_LOAD && instr[31:26] != OP_STORE
         && instr[31:26] != OP_BEQ && instr[31:26] != OP_JUMP) |-> (!rf_we_o && !dm_we_o));

endmodule

// File: tb/tb_mlite_core.sv
`timescale 1ns/1ps
module tb_mlite_core;

    localparam int MEM_AW = 6;
    localparam int WORDS  = 1 << MEM_AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              prog_we = 1'b0;
    logic              prog_sel = 1'b0;
    logic [MEM_AW-1:0] prog_addr = '0;
    logic [31:0]       prog_wdata = '0;
    logic [31:0]       pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic              rf_we_o, dm_we_o;
    logic [4:0]        rf_waddr_o;

    always #2 clk = ~clk;

    mlite_core #(.MEM_AW(MEM_AW)) dut (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_sel(prog_sel),
        .prog_addr(prog_addr), .prog_wdata(prog_wdata),
        .pc_o(pc_o), .instr_o(instr_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
        .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o),
        .dm_wdata_o(dm_wdata_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_imem [WORDS];
    logic [31:0] m_dmem [WORDS];
    logic [31:0] m_regs [32];
    logic [31:0] m_pc;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h pc=%h", req, act, exp, m_pc);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] enc_j(input int idx);
        return {6'b000010, 26'(idx)};
    endfunction

    // reference step: checks the DUT outputs for the instruction at m_pc, then advances the model
    task automatic step_and_check();
        logic [31:0] ins, a, b, se, res, npc, pc4;
        logic [5:0]  op, fn;
        int          rs, rt, rd;
        bit          e_we, e_dwe, legal_fn;
        logic [4:0]  e_wa;
        logic [31:0] e_wd, e_da, e_dd;
        string       tag;
        ins = m_imem[m_pc[MEM_AW+1:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        a = m_regs[rs]; b = m_regs[rt];
        se = {{16{ins[15]}}, ins[15:0]};
        pc4 = m_pc + 32'd4; npc = pc4;
        e_we = 0; e_wa = '0; e_wd = '0; e_dwe = 0; e_da = '0; e_dd = '0;
        tag = "R10";
        legal_fn = 1'b1;
        res = '0;
        if (op == 6'b000000) begin
            case (fn)
                6'b100000: res = a + b;
                6'b100010: res = a - b;
                6'b100100: res = a & b;
                6'b100101: res = a | b;
                6'b101010: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                default:   legal_fn = 1'b0;
            endcase
            if (legal_fn) begin
                e_we = 1; e_wa = 5'(rd); e_wd = res;
                tag = (fn == 6'b101010) ? "R3" : "R2";
            end
        end else if (op == 6'b100011) begin
            e_da = a + se; e_we = 1; e_wa = 5'(rt); e_wd = m_dmem[e_da[MEM_AW+1:2]]; tag = "R5";
        end else if (op == 6'b101011) begin
            e_dwe = 1; e_da = a + se; e_dd = b; tag = "R6";
        end else if (op == 6'b000100) begin
            tag = "R7";
            if (a == b) npc = pc4 + {se[29:0], 2'b00};
        end else if (op == 6'b000010) begin
            tag = "R8";
            npc = {pc4[31:28], ins[25:0], 2'b00};
        end
        if (e_we && e_wa == 5'd0) tag = "R4";
        check(pc_o == m_pc, "R9 pc", pc_o, m_pc);
        check(instr_o == ins, "R11 fetch", instr_o, ins);
        check(rf_we_o == e_we && (!e_we || (rf_waddr_o == e_wa && rf_wdata_o == e_wd)),
              {tag, " write-back"}, rf_wdata_o, e_wd);
        check(dm_we_o == e_dwe && (!e_dwe || (dm_addr_o == e_da && dm_wdata_o == e_dd)),
              {tag, " store"}, dm_wdata_o, e_dd);
        if (e_we && e_wa != 5'd0) m_regs[e_wa] = e_wd;
        if (e_dwe) m_dmem[e_da[MEM_AW+1:2]] = e_dd;
        m_pc = npc;
    endtask

    task automatic load_and_run(input int cycles);
        rst = 1'b1;
        for (int i = 0; i < 2 * WORDS; i++) begin
            @(negedge clk);
            prog_we = 1'b1;
            prog_sel = (i >= WORDS);
            prog_addr = MEM_AW'(i % WORDS);
            prog_wdata = (i < WORDS) ? m_imem[i] : m_dmem[i - WORDS];
        end
        @(negedge clk);
        prog_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < 32; r++) m_regs[r] = '0;
        m_pc = '0;
        #1;
        check(pc_o == 32'd0, "R1 reset pc", pc_o, 32'd0);
        for (int c = 0; c < cycles; c++) begin
            step_and_check();
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < WORDS; i++) begin
            m_imem[i] = enc_i(6'b000100, 0, 0, -1);
            m_dmem[i] = $urandom;
        end
        m_dmem[0] = 32'd5;
        m_dmem[1] = 32'hFFFF_FFFD;
        m_dmem[2] = 32'h7FFF_FFFF;
        m_dmem[3] = 32'h8000_0000;
        // directed program
        m_imem[0]  = enc_i(6'b100011, 0, 1, 0);
        m_imem[1]  = enc_i(6'b100011, 0, 2, 4);
        m_imem[2]  = enc_i(6'b100011, 0, 3, 8);
        m_imem[3]  = enc_i(6'b100011, 0, 4, 12);
        m_imem[4]  = enc_r(1, 2, 5, 6'b100000);
        m_imem[5]  = enc_r(2, 1, 6, 6'b100010);
        m_imem[6]  = enc_r(2, 1, 7, 6'b101010);   // R3: -3 < 5
        m_imem[7]  = enc_r(1, 2, 7, 6'b101010);   // R3: 5 < -3 false
        m_imem[8]  = enc_r(4, 3, 8, 6'b101010);   // R3: min < max
        m_imem[9]  = enc_r(3, 1, 9, 6'b100000);   // R2: wraps
        m_imem[10] = enc_r(1, 2, 10, 6'b100100);
        m_imem[11] = enc_r(1, 2, 11, 6'b100101);
        m_imem[12] = enc_r(1, 1, 0, 6'b100000);   // R4: write to register 0
        m_imem[13] = enc_r(0, 0, 12, 6'b100000);  // R4: register 0 still zero
        m_imem[14] = enc_i(6'b101011, 6, 5, -4);  // R6: negative base and offset
        m_imem[15] = enc_i(6'b100011, 0, 13, -12);// R5: same word back
        m_imem[16] = enc_i(6'b000100, 1, 2, 5);   // R7: not taken
        m_imem[17] = enc_i(6'b000100, 7, 0, 2);   // R7: taken, value written earlier
        m_imem[18] = enc_r(1, 1, 14, 6'b100000);
        m_imem[19] = enc_r(1, 1, 15, 6'b100000);
        m_imem[20] = enc_j(24);                   // R8
        m_imem[24] = enc_i(6'b101011, 0, 1, 20);
        m_imem[25] = enc_r(1, 2, 16, 6'b000000);  // R10: unknown function
        m_imem[26] = enc_i(6'b001000, 1, 17, 7);  // R10: unknown opcode
        m_imem[27] = enc_i(6'b000100, 0, 0, -1);  // R7: backward self branch
        load_and_run(40);

        // seeded random programs
        for (int p = 0; p < 10; p++) begin
            for (int i = 0; i < WORDS; i++) begin
                int k;
                k = int'($urandom % 32);
                m_dmem[i] = $urandom;
                if (k < 14) begin
                    logic [5:0] fns [5];
                    fns = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
                    m_imem[i] = enc_r(int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
                                      fns[$urandom % 5]);
                end else if (k < 20) begin
                    m_imem[i] = enc_i(6'b100011, int'($urandom % 8), int'($urandom % 8), int'($urandom));
                end else if (k < 25) begin
                    m_imem[i] = enc_i(6'b101011, int'($urandom % 8), int'($urandom % 8), int'($urandom));
                end else if (k < 28) begin
                    m_imem[i] = enc_i(6'b000100, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4));
                end else if (k < 30) begin
                    m_imem[i] = enc_j((i + 1 + int'($urandom % 4)) % WORDS);
                end else if (k < 31) begin
                    m_imem[i] = enc_r(1, 2, 3, 6'b000011);
                end else begin
                    m_imem[i] = enc_i(6'b001101, 1, 2, 3);
                end
            end
            load_and_run(200);
        end

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", n_chk);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    end

endmodule